// File: doc/BRIEF.md
# GCI Frame Serial Multiplexer

This block carries one 32-bit channel of a four-byte time-division frame that repeats at 8 kHz, in both directions at once. It runs directly on the bit clock, where one data bit lasts two bit-clock cycles. A rising frame sync marks where a frame begins.

On the transmit side, the parallel fields are captured when a frame begins and sent one bit at a time, MSB first. The fields are two 8-bit bearer bytes, an 8-bit monitor byte, a 2-bit D field, a 4-bit command/indicate field and the two handshake bits A and E. On the receive side, the same layout is shifted in from the serial input. At the end of each frame the block presents the received fields together with a one-cycle valid strobe.

The caller can release the A and E bit positions from the output. During those bit times the output enable is low, so an external pull-up sets the line level. If no new frame sync arrives, the bit counter keeps running one frame after another. A frame sync that arrives at an unexpected position restarts the frame at once.

Top module: `gci_frame_mux`

## Requirements
- R1: While reset is low, and after reset until the first rising edge of `fsync` is sampled, `dout_oe` is 0 and `rx_valid` is 0.
- R2: A rising edge of `fsync` is a low-to-high change between two consecutive `bclk` rising edges. The `bclk` edge that samples it is the frame start. A frame is 64 `bclk` cycles long, and data bit k (k = 0 to 31) occupies cycles 2k and 2k+1 after the frame start.
- R3: The transmit word is {tx_b1, tx_b2, tx_mon, tx_d, tx_ci, tx_a, tx_e}, so bit 31 is the MSB of tx_b1 and bit 0 is tx_e. Bit k of the serial order is word bit 31-k. `dout` takes each new bit on the first edge of its bit period and holds it for both cycles.
- R4: The transmit fields and the release controls are captured at the frame start. Changing them later in the frame does not alter the bits sent in that frame.
- R5: `din` is sampled on the second edge of each bit period. The received word is split using the same layout as R3: rx_b1 = bits 31..24, rx_b2 = bits 23..16, rx_mon = bits 15..8, rx_d = bits 7..6, rx_ci = bits 5..2, rx_a = bit 1, rx_e = bit 0.
- R6: `rx_valid` is high for exactly one cycle, the last cycle (cycle 63) of a frame. The received fields update at that point and then hold until the next strobe.
- R7: When `tx_rel_a` is 1, `dout_oe` is 0 during bit period 30 (the A bit). When `tx_rel_e` is 1, `dout_oe` is 0 during bit period 31 (the E bit). For every other bit period of an active frame, `dout_oe` is 1.
- R8: A rising edge of `fsync` at any point in a frame restarts the frame from cycle 0. The interrupted frame produces no `rx_valid`.
- R9: Without a new frame sync, the counter wraps after cycle 63 and starts a new frame, capturing the transmit fields again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock, two cycles per data bit |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync; its rising edge marks the frame start |
| din | input | 1 | Serial receive data |
| tx_b1 | input | 8 | First bearer byte to send |
| tx_b2 | input | 8 | Second bearer byte to send |
| tx_mon | input | 8 | Monitor byte to send |
| tx_d | input | 2 | D field to send |
| tx_ci | input | 4 | Command/indicate field to send |
| tx_a | input | 1 | A handshake bit to send |
| tx_e | input | 1 | E handshake bit to send |
| tx_rel_a | input | 1 | Release the A bit position (output enable low) |
| tx_rel_e | input | 1 | Release the E bit position (output enable low) |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Output enable for dout |
| rx_b1 | output | 8 | Received first bearer byte |
| rx_b2 | output | 8 | Received second bearer byte |
| rx_mon | output | 8 | Received monitor byte |
| rx_d | output | 2 | Received D field |
| rx_ci | output | 4 | Received command/indicate field |
| rx_a | output | 1 | Received A bit |
| rx_e | output | 1 | Received E bit |
| rx_valid | output | 1 | One-cycle strobe when the received fields are new |

## Verification
If the bit counter is misaligned, the serial output is wrong within two bit-clock cycles of the frame start. The error is either a shifted transmit bit or a bit that changes in the middle of its period. The receive side shows it only at the end of the frame, as a received word rotated by one bit or a strobe in the wrong cycle. An error in capture timing or in the release logic shows up either as bits that follow a mid-frame change to the inputs, or as the output enable dropping in the wrong bit period.

// File: rtl/gci_frame_mux.sv
module gci_frame_mux (
  input  logic       bclk,
  input  logic       rst_n,
  input  logic       fsync,
  input  logic       din,
  input  logic [7:0] tx_b1,
  input  logic [7:0] tx_b2,
  input  logic [7:0] tx_mon,
  input  logic [1:0] tx_d,
  input  logic [3:0] tx_ci,
  input  logic       tx_a,
  input  logic       tx_e,
  input  logic       tx_rel_a,
  input  logic       tx_rel_e,
  output logic       dout,
  output logic       dout_oe,
  output logic [7:0] rx_b1,
  output logic [7:0] rx_b2,
  output logic [7:0] rx_mon,
  output logic [1:0] rx_d,
  output logic [3:0] rx_ci,
  output logic       rx_a,
  output logic       rx_e,
  output logic       rx_valid
);
  localparam int NBITS = 32;
  localparam int CPB   = 2;
  localparam int NCYC  = NBITS * CPB;
  localparam int CW    = $clog2(NCYC);
  localparam int IW    = CW - 1;

  logic [CW-1:0]    cnt;
  logic             active;
  logic             fs_q;
  logic             rel_a_q, rel_e_q;
  logic [NBITS-1:0] tx_word;
  logic [NBITS-2:0] rx_sh;
  logic [NBITS-1:0] rx_word;

  wire [NBITS-1:0] tx_in = {tx_b1, tx_b2, tx_mon, tx_d, tx_ci, tx_a, tx_e};
  wire             start = fsync & ~fs_q;
  wire             wrap  = active && (cnt == CW'(NCYC - 1));
  wire             load  = start | wrap;
  wire [IW-1:0]    idx   = cnt[CW-1:1] + IW'(1);

  function automatic logic oe_at(logic [IW-1:0] i, logic ra, logic re);
    return !((i == IW'(NBITS - 2) && ra) || (i == IW'(NBITS - 1) && re));
  endfunction

  always_ff @(posedge bclk) begin
    if (!rst_n) begin
      cnt      <= '0;
      active   <= 1'b0;
      fs_q     <= 1'b0;
      rel_a_q  <= 1'b0;
      rel_e_q  <= 1'b0;
      tx_word  <= '0;
      rx_sh    <= '0;
      rx_word  <= '0;
      dout     <= 1'b0;
      dout_oe  <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      fs_q     <= fsync;
      rx_valid <= 1'b0;
      if (load) begin
        active  <= 1'b1;
        cnt     <= '0;
        tx_word <= tx_in;
        rel_a_q <= tx_rel_a;
        rel_e_q <= tx_rel_e;
        dout    <= tx_in[NBITS-1];
        dout_oe <= oe_at('0, tx_rel_a, tx_rel_e);
      end else if (active) begin
        cnt <= cnt + CW'(1);
        if (cnt[0]) begin
          dout    <= tx_word[IW'(NBITS - 1) - idx];
          dout_oe <= oe_at(idx, rel_a_q, rel_e_q);
        end else begin
          rx_sh <= {rx_sh[NBITS-3:0], din};
          if (cnt == CW'(NCYC - 2)) begin
            rx_word  <= {rx_sh, din};
            rx_valid <= 1'b1;
          end
        end
      end
    end
  end

  assign rx_b1  = rx_word[31:24];
  assign rx_b2  = rx_word[23:16];
  assign rx_mon = rx_word[15:8];
  assign rx_d   = rx_word[7:6];
  assign rx_ci  = rx_word[5:2];
  assign rx_a   = rx_word[1];
  assign rx_e   = rx_word[0];
endmodule

// File: rtl/gci_frame_mux_chk.sv
module gci_frame_mux_chk (
  input logic       bclk,
  input logic       rst_n,
  input logic       fsync,
  input logic       dout,
  input logic       dout_oe,
  input logic       rx_valid,
  input logic       active,
  input logic [5:0] cnt
);
  a_r1_idle_no_drive: assert property (@(posedge bclk) disable iff (!rst_n)
    !active |-> (!dout_oe && !rx_valid));

  a_r2_sync_restarts: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(fsync) |=> (cnt == 6'd0 && active));

  a_r8_realign_any_pos: assert property (@(posedge bclk) disable iff (!rst_n)
    ($rose(fsync) && cnt != 6'd63) |=> (cnt == 6'd0));

  a_r3_hold_two_cycles: assert property (@(posedge bclk) disable iff (!rst_n)
    (active && cnt[0]) |-> ($stable(dout) && $stable(dout_oe)));

  a_r6_strobe_last_cycle: assert property (@(posedge bclk) disable iff (!rst_n)
    rx_valid |-> (cnt == 6'd63));

  a_r6_strobe_single: assert property (@(posedge bclk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind gci_frame_mux gci_frame_mux_chk u_chk (
  .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .dout(dout), .dout_oe(dout_oe),
  .rx_valid(rx_valid), .active(active), .cnt(cnt)
);

// File: tb/sim_gci_frame_mux.sv
`timescale 1ns/1ps
module sim_gci_frame_mux;
  localparam int CLK_P = 244;

  logic bclk = 1'b0, rst_n = 1'b0, fsync = 1'b0, din = 1'b0;
  logic [7:0] tx_b1 = '0, tx_b2 = '0, tx_mon = '0;
  logic [1:0] tx_d = '0;
  logic [3:0] tx_ci = '0;
  logic tx_a = 1'b0, tx_e = 1'b0, tx_rel_a = 1'b0, tx_rel_e = 1'b0;
  logic dout, dout_oe, rx_a, rx_e, rx_valid;
  logic [7:0] rx_b1, rx_b2, rx_mon;
  logic [1:0] rx_d;
  logic [3:0] rx_ci;

  int n_chk = 0, n_bad = 0;
  logic [31:0] last_rx = '0;
  bit have_last = 0;
  bit done = 0;

  always #(CLK_P/2) bclk = ~bclk;

  gci_frame_mux u0 (.*);

  localparam logic [31:0] TXV [4] = '{32'hA53C81E6, 32'h00FF0F5A, 32'hFFFFFFFF, 32'h12345678};
  localparam logic [31:0] RXV [4] = '{32'h5AC37E19, 32'hF00F3CC3, 32'h00000000, 32'h9ABCDEF1};
  localparam logic [1:0]  RLV [4] = '{2'b00, 2'b10, 2'b01, 2'b11};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_tx(logic [31:0] w, logic ra, logic re);
    {tx_b1, tx_b2, tx_mon, tx_d, tx_ci, tx_a, tx_e} = w;
    tx_rel_a = ra;
    tx_rel_e = re;
  endtask

  task automatic run_frame(logic [31:0] txw, logic [31:0] rxw, logic ra, logic re,
                           bit use_fs, bit perturb);
    set_tx(txw, ra, re);
    if (use_fs) fsync = 1'b1;
    for (int c = 0; c < 64; c++) begin
      @(negedge bclk);
      if (c == 15) fsync = 1'b0;
      chk($sformatf("R3 dout c=%0d", c), {31'd0, dout}, {31'd0, txw[31 - c/2]});
      chk($sformatf("R7 oe c=%0d", c), {31'd0, dout_oe},
          {31'd0, !((c/2 == 30 && ra) || (c/2 == 31 && re))});
      chk($sformatf("R6 valid c=%0d", c), {31'd0, rx_valid}, {31'd0, c == 63});
      if (c == 5 && have_last)
        chk("R6 fields hold", {rx_b1, rx_b2, rx_mon, rx_d, rx_ci, rx_a, rx_e}, last_rx);
      if (c == 10 && perturb) set_tx(~txw, !ra, !re);
      din = rxw[31 - c/2];
      if (c == 63) begin
        chk("R5 rx_b1", {24'd0, rx_b1}, {24'd0, rxw[31:24]});
        chk("R5 rx_b2", {24'd0, rx_b2}, {24'd0, rxw[23:16]});
        chk("R5 rx_mon", {24'd0, rx_mon}, {24'd0, rxw[15:8]});
        chk("R5 rx_d/ci/a/e", {24'd0, rx_d, rx_ci, rx_a, rx_e}, {24'd0, rxw[7:0]});
        last_rx = rxw;
        have_last = 1;
      end
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge bclk);
    chk("R1 reset oe", {31'd0, dout_oe}, 32'd0);
    chk("R1 reset valid", {31'd0, rx_valid}, 32'd0);
    rst_n = 1'b1;
    for (int c = 0; c < 70; c++) begin
      @(negedge bclk);
      din = c[0];
      if (dout_oe || rx_valid) chk("R1 idle before sync", {30'd0, dout_oe, rx_valid}, 32'd0);
    end
    chk("R1 idle after 70 cycles", {30'd0, dout_oe, rx_valid}, 32'd0);

    for (int v = 0; v < 4; v++)
      run_frame(TXV[v], RXV[v], RLV[v][1], RLV[v][0], 1'b1, 1'b0);

    // R4: inputs changed mid-frame must not alter this frame
    run_frame(32'hC3A50F96, 32'h13579BDF, 1'b0, 1'b1, 1'b1, 1'b1);
    // R9: no sync, counter wraps into a new frame
    run_frame(32'h6E2D4B87, 32'h2468ACE0, 1'b1, 1'b0, 1'b0, 1'b0);

    // R8: partial frame (flywheel start), then an early sync realigns
    set_tx(32'hDEADBEEF, 1'b0, 1'b0);
    for (int c = 0; c < 21; c++) begin
      @(negedge bclk);
      din = 1'b1;
      chk($sformatf("R8 no valid partial c=%0d", c), {31'd0, rx_valid}, 32'd0);
    end
    run_frame(32'h0F1E2D3C, 32'hB4C3D2E1, 1'b1, 1'b1, 1'b1, 1'b0);
    run_frame(32'h89ABCDEF, 32'h76543210, 1'b0, 1'b0, 1'b0, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule